// File: doc/BRIEF.md
# Oversampled SPI Slave Byte Port

This block is the slave end of a four-wire SPI link that lives entirely in the local system clock domain. The serial clock, the slave select and the incoming data pin are never used as clocks. Each of them passes through a two-flop synchronizer. Serial clock edges are then found by comparing successive synchronized samples. Bytes are exchanged MSB first in any of the four clock polarity and phase combinations. The local side writes a transmit byte and reads received bytes from a one-entry buffer.

The control FSM has five states:

- `S_OFF`: disabled, or parked after a fault.
- `S_IDLE`: enabled but not selected.
- `S_SHIFT`: bits are moving.
- `S_DONE`: a one-cycle end-of-byte state.
- `S_ABORT`: a one-cycle fault state.

The transitions are:

- `S_OFF` → `S_IDLE` when the enable is set.
- `S_IDLE` → `S_SHIFT` when the synchronized select goes low. On this move the transmit byte is loaded.
- `S_SHIFT` → `S_DONE` on the eighth sampling edge.
- `S_SHIFT` → `S_IDLE` when select rises with no bit in flight.
- `S_SHIFT` → `S_ABORT` when select rises in the middle of a byte.
- `S_DONE` → `S_SHIFT` if still selected. The next transmit byte is reloaded on this move.
- `S_DONE` → `S_IDLE` otherwise.
- `S_ABORT` → `S_OFF`, always.
- Any state except `S_ABORT` → `S_OFF` when the enable is cleared.

A received byte that arrives while the buffer still holds an unread byte is thrown away, and the overrun flag is set. The old byte is kept. The serial clock must run no faster than a quarter of the system clock.

Top module: `spi_os_slave`

## Requirements
- R1: After reset: `rx_full`, `ovr`, `mode_fault`, `irq`, `byte_done`, `spi_en` and `miso_oe` are all 0.
- R2: Each mode is given by `cpol` (idle level of `sck`) and `cpha`.
  - With `cpha`=0, data is sampled on the edge leaving the idle level, and MISO changes on the edge returning to it.
  - With `cpha`=1, MISO changes on the edge leaving idle, and data is sampled on the edge returning to it.
  - Both directions are MSB first. MISO starts each byte with bit 7 of the transmit register.
- R3: While `ss_n` is high, `sck` transitions have no effect, no byte is received, and `miso_oe` is 0. `miso` is then high impedance.
- R4: `byte_done` is a one-cycle pulse, exactly one per completed byte, including back-to-back bytes under one continuous select.
- R5: A completed byte appears on `rx_data` and sets `rx_full`. A `rd_data` strobe clears `rx_full`.
- R6: If a byte completes while `rx_full` is 1, `rx_data` keeps the older byte, the new byte is discarded, and `ovr` becomes 1.
- R7: `ovr` is cleared only by a `rd_stat` strobe seen while `ovr` is 1, followed by a `rd_data` strobe. A `rd_data` strobe alone leaves it set.
- R8: When `ss_n` rises after at least one bit of a byte and before its eighth bit:
  - the byte is dropped, `mode_fault` becomes 1, and `spi_en` becomes 0;
  - no further byte is received until a `ctl_wr` strobe with `ctl_en`=1 is given. That strobe also clears `mode_fault`.
- R9: `irq` equals `irq_en` AND (`rx_full` OR `ovr` OR `mode_fault`).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cpol | input | 1 | Serial clock idle level |
| cpha | input | 1 | Clock phase select |
| ctl_wr | input | 1 | Enable write strobe |
| ctl_en | input | 1 | Enable value written by ctl_wr |
| irq_en | input | 1 | Interrupt enable |
| tx_wr | input | 1 | Transmit register write strobe |
| tx_data | input | 8 | Transmit byte |
| rd_data | input | 1 | Data read strobe |
| rd_stat | input | 1 | Status read strobe |
| sck | input | 1 | Serial clock from master |
| ss_n | input | 1 | Active-low slave select |
| mosi | input | 1 | Serial data from master |
| miso | output | 1 | Serial data to master, high impedance when not driven |
| miso_oe | output | 1 | MISO drive enable |
| rx_data | output | 8 | Receive buffer |
| rx_full | output | 1 | Receive buffer holds an unread byte |
| ovr | output | 1 | Overrun flag |
| mode_fault | output | 1 | Select-deasserted-mid-byte flag |
| spi_en | output | 1 | Current enable state |
| byte_done | output | 1 | One-cycle end-of-byte pulse |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with its default parameters: 8-bit bytes and two synchronizer stages. It drives the serial clock at a half period of six system clocks. This leaves about three cycles of margin over the synchronizer and edge-detect latency, so MISO is always settled before the master samples it in all four modes. Eight-bit bytes keep every overrun, clear-sequence and partial-byte fault scenario to a handful of short transfers.

// File: rtl/spi_os_pkg.sv
package spi_os_pkg;
    typedef enum logic [2:0] {
        S_OFF   = 3'd0,
        S_IDLE  = 3'd1,
        S_SHIFT = 3'd2,
        S_DONE  = 3'd3,
        S_ABORT = 3'd4
    } spi_state_t;
endpackage

// File: rtl/spi_os_sync.sv
module spi_os_sync #(
    parameter int W      = 3,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] rst_val,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) chain[i] <= rst_val;
        end else begin
            chain[0] <= d;
            for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/spi_os_core.sv
module spi_os_core
    import spi_os_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          sck_s,
    input  logic          ss_s,
    input  logic          mosi_s,
    output logic          miso_bit,
    output logic          miso_oe,
    output logic          done,
    output logic [DW-1:0] rx_byte,
    output logic          spi_en,
    output logic          mode_fault
);
    localparam int CW = $clog2(DW);
    localparam logic [CW-1:0] LAST = CW'(DW - 1);

    spi_state_t    state_q, state_d;
    logic          sck_q;
    logic [DW-1:0] tx_q, sh_out, sh_in;
    logic [CW-1:0] bitcnt;
    logic          lead, trail, samp_edge, out_edge;

    assign lead      = (sck_q == cpol) && (sck_s != cpol);
    assign trail     = (sck_q != cpol) && (sck_s == cpol);
    assign samp_edge = cpha ? trail : lead;
    assign out_edge  = cpha ? lead  : trail;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_OFF;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_OFF:   if (spi_en) state_d = S_IDLE;
            S_IDLE:  if (!spi_en) state_d = S_OFF;
                     else if (!ss_s) state_d = S_SHIFT;
            S_SHIFT: if (!spi_en) state_d = S_OFF;
                     else if (ss_s) state_d = (bitcnt != '0) ? S_ABORT : S_IDLE;
                     else if (samp_edge && bitcnt == LAST) state_d = S_DONE;
            S_DONE:  if (!spi_en) state_d = S_OFF;
                     else if (ss_s) state_d = S_IDLE;
                     else state_d = S_SHIFT;
            S_ABORT: state_d = S_OFF;
            default: state_d = S_OFF;
        endcase
    end

    // outputs and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sck_q      <= 1'b0;
            tx_q       <= '0;
            sh_out     <= '0;
            sh_in      <= '0;
            bitcnt     <= '0;
            spi_en     <= 1'b0;
            mode_fault <= 1'b0;
        end else begin
            sck_q <= sck_s;
            if (tx_wr) tx_q <= tx_data;
            if (state_q == S_ABORT) begin
                spi_en     <= 1'b0;
                mode_fault <= 1'b1;
            end else if (ctl_wr) begin
                spi_en <= ctl_en;
                if (ctl_en) mode_fault <= 1'b0;
            end
            unique case (state_q)
                S_IDLE, S_DONE: begin
                    sh_out <= tx_wr ? tx_data : tx_q;
                    bitcnt <= '0;
                end
                S_SHIFT: begin
                    if (ss_s) begin
                        bitcnt <= '0;
                    end else if (samp_edge) begin
                        sh_in  <= {sh_in[DW-2:0], mosi_s};
                        bitcnt <= bitcnt + 1'b1;
                    end else if (out_edge && bitcnt != '0) begin
                        sh_out <= {sh_out[DW-2:0], 1'b0};
                    end
                end
                S_OFF, S_ABORT: bitcnt <= '0;
                default: bitcnt <= '0;
            endcase
        end
    end

    assign done     = (state_q == S_DONE);
    assign rx_byte  = sh_in;
    assign miso_bit = sh_out[DW-1];
    assign miso_oe  = !ss_s && (state_q == S_IDLE || state_q == S_SHIFT || state_q == S_DONE);

    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r3_no_drive_deselected: assert property (@(posedge clk) disable iff (!rst_n)
        ss_s |-> !miso_oe);
    a_r8_fault_disables: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ABORT) |=> (mode_fault && !spi_en && state_q == S_OFF));
    a_r8_no_done_after_abort: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == S_ABORT) |=> !done);
endmodule

// File: rtl/spi_os_rxbuf.sv
module spi_os_rxbuf #(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          done,
    input  logic [DW-1:0] rx_byte,
    input  logic          rd_data,
    input  logic          rd_stat,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          ovr
);
    logic armed;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rx_data <= '0;
            rx_full <= 1'b0;
            ovr     <= 1'b0;
            armed   <= 1'b0;
        end else begin
            if (done && (!rx_full || rd_data)) begin
                rx_data <= rx_byte;
                rx_full <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
            end
            if (rd_stat && ovr) armed <= 1'b1;
            else if (rd_data)   armed <= 1'b0;
            if (done && rx_full && !rd_data) ovr <= 1'b1;
            else if (rd_data && armed)       ovr <= 1'b0;
        end
    end

    a_r6_keep_old: assert property (@(posedge clk) disable iff (!rst_n)
        (done && rx_full && !rd_data) |=> (ovr && rx_full && rx_data == $past(rx_data)));
    a_r5_fill: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !rx_full) |=> (rx_full && rx_data == $past(rx_byte)));
    a_r7_clear_needs_stat: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(ovr)) |-> $past(rd_data));
endmodule

// File: rtl/spi_os_slave.sv
module spi_os_slave #(
    parameter int DW          = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cpol,
    input  logic          cpha,
    input  logic          ctl_wr,
    input  logic          ctl_en,
    input  logic          irq_en,
    input  logic          tx_wr,
    input  logic [DW-1:0] tx_data,
    input  logic          rd_data,
    input  logic          rd_stat,
    input  logic          sck,
    input  logic          ss_n,
    input  logic          mosi,
    output logic          miso,
    output logic          miso_oe,
    output logic [DW-1:0] rx_data,
    output logic          rx_full,
    output logic          ovr,
    output logic          mode_fault,
    output logic          spi_en,
    output logic          byte_done,
    output logic          irq
);
    logic [2:0]    pins_s;
    logic          miso_bit;
    logic [DW-1:0] rx_byte;

    spi_os_sync #(.W(3), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .rst_val (3'b010),
        .d       ({mosi, ss_n, sck}),
        .q       (pins_s)
    );

    spi_os_core #(.DW(DW)) u_core (
        .clk        (clk),
        .rst_n      (rst_n),
        .cpol       (cpol),
        .cpha       (cpha),
        .ctl_wr     (ctl_wr),
        .ctl_en     (ctl_en),
        .tx_wr      (tx_wr),
        .tx_data    (tx_data),
        .sck_s      (pins_s[0]),
        .ss_s       (pins_s[1]),
        .mosi_s     (pins_s[2]),
        .miso_bit   (miso_bit),
        .miso_oe    (miso_oe),
        .done       (byte_done),
        .rx_byte    (rx_byte),
        .spi_en     (spi_en),
        .mode_fault (mode_fault)
    );

    spi_os_rxbuf #(.DW(DW)) u_rxbuf (
        .clk     (clk),
        .rst_n   (rst_n),
        .done    (byte_done),
        .rx_byte (rx_byte),
        .rd_data (rd_data),
        .rd_stat (rd_stat),
        .rx_data (rx_data),
        .rx_full (rx_full),
        .ovr     (ovr)
    );

    assign miso = miso_oe ? miso_bit : 1'bz;
    assign irq  = irq_en && (rx_full || ovr || mode_fault);

    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> irq_en);
endmodule

// File: tb/spi_os_slave_bench.sv
module spi_os_slave_bench;
    localparam int HALF = 6;

    logic clk = 1'b0, rst_n = 1'b0;
    logic cpol = 1'b0, cpha = 1'b0, ctl_wr = 1'b0, ctl_en = 1'b0, irq_en = 1'b0;
    logic tx_wr = 1'b0, rd_data = 1'b0, rd_stat = 1'b0;
    logic [7:0] tx_data = 8'h00;
    logic sck = 1'b0, ss_n = 1'b1, mosi = 1'b0;
    logic miso, miso_oe, rx_full, ovr, mode_fault, spi_en, byte_done, irq;
    logic [7:0] rx_data;
    int checks = 0, fails = 0, done_cnt = 0, done_wide = 0;
    logic done_prev = 1'b0;
    bit   finished = 0;

    always #5 clk = ~clk;

    spi_os_slave u_spi_os_slave (
        .clk(clk), .rst_n(rst_n), .cpol(cpol), .cpha(cpha), .ctl_wr(ctl_wr),
        .ctl_en(ctl_en), .irq_en(irq_en), .tx_wr(tx_wr), .tx_data(tx_data),
        .rd_data(rd_data), .rd_stat(rd_stat), .sck(sck), .ss_n(ss_n), .mosi(mosi),
        .miso(miso), .miso_oe(miso_oe), .rx_data(rx_data), .rx_full(rx_full),
        .ovr(ovr), .mode_fault(mode_fault), .spi_en(spi_en), .byte_done(byte_done),
        .irq(irq)
    );

    always @(posedge clk) begin
        if (byte_done) done_cnt <= done_cnt + 1;
        if (byte_done && done_prev) done_wide <= done_wide + 1;
        done_prev <= byte_done;
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clks(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic strobe(ref logic s);
        @(negedge clk); s = 1'b1; @(negedge clk); s = 1'b0;
    endtask

    task automatic enable(input logic v);
        ctl_en = v; strobe(ctl_wr);
    endtask

    task automatic load_tx(input logic [7:0] v);
        tx_data = v; strobe(tx_wr);
    endtask

    task automatic set_mode(input logic p, input logic h);
        cpol = p; cpha = h; sck = p; clks(8);
    endtask

    task automatic xfer(input logic [7:0] mo, output logic [7:0] mi, input int nbits);
        mi = 8'h00;
        for (int i = 7; i > 7 - nbits; i--) begin
            if (!cpha) begin
                mosi = mo[i]; clks(HALF);
                mi[i] = miso; sck = ~cpol; clks(HALF);
                sck = cpol;
            end else begin
                sck = ~cpol; mosi = mo[i]; clks(HALF);
                mi[i] = miso; sck = cpol; clks(HALF);
            end
        end
    endtask

    task automatic one_byte(input logic [7:0] mo, output logic [7:0] mi);
        ss_n = 1'b0; clks(HALF);
        xfer(mo, mi, 8);
        clks(HALF); ss_n = 1'b1; clks(8);
    endtask

    task automatic t_reset();
        chk("R1 rx_full", rx_full, 0);
        chk("R1 ovr", ovr, 0);
        chk("R1 mode_fault", mode_fault, 0);
        chk("R1 irq", irq, 0);
        chk("R1 byte_done", byte_done, 0);
        chk("R1 spi_en", spi_en, 0);
        chk("R1 miso_oe", miso_oe, 0);
    endtask

    task automatic t_modes();
        logic [7:0] mi;
        logic [7:0] mo [4] = '{8'hA5, 8'h3C, 8'h81, 8'h6E};
        logic [7:0] so [4] = '{8'h5A, 8'hC3, 8'h7E, 8'h91};
        for (int m = 0; m < 4; m++) begin
            set_mode(m[1], m[0]);
            load_tx(so[m]);
            one_byte(mo[m], mi);
            chk($sformatf("R2 mode%0d mosi->rx", m), rx_data, mo[m]);
            chk($sformatf("R2 mode%0d tx->miso", m), mi, so[m]);
            chk("R5 full set", rx_full, 1);
            strobe(rd_data); clks(1);
            chk("R5 full cleared by read", rx_full, 0);
        end
    endtask

    task automatic t_ignore();
        logic [7:0] mi;
        set_mode(1'b0, 1'b0);
        ss_n = 1'b1;
        for (int i = 0; i < 8; i++) begin
            mosi = i[0]; clks(HALF); sck = 1'b1; clks(HALF); sck = 1'b0;
            chk("R3 miso_oe low while deselected", miso_oe, 0);
        end
        clks(8);
        chk("R3 no byte while deselected", rx_full, 0);
        load_tx(8'hC5);
        one_byte(8'h42, mi);
        chk("R3 next selected byte clean", rx_data, 8'h42);
        strobe(rd_data);
    endtask

    task automatic t_b2b();
        logic [7:0] m1, m2;
        int base;
        set_mode(1'b1, 1'b1);
        load_tx(8'h96);
        base = done_cnt;
        ss_n = 1'b0; clks(HALF);
        xfer(8'h12, m1, 8);
        clks(2); strobe(rd_data);
        xfer(8'h34, m2, 8);
        clks(HALF); ss_n = 1'b1; clks(8);
        chk("R4 two pulses for two bytes", done_cnt - base, 2);
        chk("R4 pulses one cycle wide", done_wide, 0);
        chk("R4 second byte received", rx_data, 8'h34);
        chk("R2 reloaded tx on second byte", m2, 8'h96);
        strobe(rd_data);
    endtask

    task automatic t_overrun();
        logic [7:0] mi;
        set_mode(1'b0, 1'b0);
        irq_en = 1'b0;
        one_byte(8'h11, mi);
        chk("R9 irq masked", irq, 0);
        irq_en = 1'b1; clks(1);
        chk("R9 irq on full", irq, 1);
        one_byte(8'h22, mi);
        chk("R6 old byte kept", rx_data, 8'h11);
        chk("R6 ovr set", ovr, 1);
        strobe(rd_data); clks(1);
        chk("R7 data read alone keeps ovr", ovr, 1);
        chk("R9 irq on ovr", irq, 1);
        strobe(rd_stat); strobe(rd_data); clks(1);
        chk("R7 stat then data clears ovr", ovr, 0);
        chk("R9 irq drops", irq, 0);
        irq_en = 1'b0;
    endtask

    task automatic t_fault();
        logic [7:0] mi;
        set_mode(1'b0, 1'b1);
        load_tx(8'hE7);
        ss_n = 1'b0; clks(HALF);
        xfer(8'hF0, mi, 3);
        ss_n = 1'b1; clks(8);
        chk("R8 fault flag", mode_fault, 1);
        chk("R8 enable cleared", spi_en, 0);
        chk("R8 partial byte dropped", rx_full, 0);
        one_byte(8'h77, mi);
        chk("R8 no byte until re-enabled", rx_full, 0);
        enable(1'b1); clks(2);
        chk("R8 rewrite clears fault", mode_fault, 0);
        one_byte(8'h5C, mi);
        chk("R8 resumes after rewrite", rx_data, 8'h5C);
        chk("R8 tx after resume", mi, 8'hE7);
        strobe(rd_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            fails++; checks++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        clks(4);
        t_reset();
        rst_n = 1'b1;
        clks(4);
        enable(1'b1); clks(2);
        t_modes();
        t_ignore();
        t_b2b();
        t_overrun();
        t_fault();
        finished = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule